// File: doc/BRIEF.md
# Tuning Synthesiser Serial Control Port

This block is an I2C slave that loads the programming registers of a PLL tuning synthesiser and returns a status byte to the bus master. SCL and SDA are brought into the system clock domain through a short synchroniser. Start and stop conditions are detected there, and the slave pulls SDA low through a single open-drain enable. A seven-bit slave address is matched, and two of its bits come from a strap input, so that several synthesisers can share one bus.

In a write transfer, data bytes arrive in pairs. The top bit of the first byte of each pair picks its meaning. When it is clear, the pair carries the 15-bit divider ratio. When it is set, the pair carries the charge-pump and test bits followed by the six output-port enables. Pairs may follow one another in a single transfer until a stop. A divider update reaches the output only when both of its bytes have been taken. In a read transfer the block sends a status byte, and it sends a fresh one for every byte the master acknowledges. That byte holds a power-on flag, the lock input, three port levels and the ADC code. The power-on flag is cleared only by a read that ends with a stop.

Top module: `synth_ctl_i2c`

## Requirements
- R1: The block acknowledges an address byte only when its seven upper bits, sent MSB first, equal 1,1,0,0,0 followed by addr_sel_i[1], addr_sel_i[0]. Bit 0 of that byte set to 1 selects read and set to 0 selects write. On any other address SDA is left released.
- R2: In a write transfer, every complete data byte is acknowledged with SDA held low during its ninth clock.
- R3: A first-of-pair byte with bit 7 = 0 is divider byte A, and the next byte is divider byte B. div_ratio_o becomes {A[6:0], B[7:0]}.
- R4: div_ratio_o does not change after byte A alone. If the transfer ends before byte B, the staged byte is dropped, and the next transfer begins again with a first-of-pair byte.
- R5: A first-of-pair byte with bit 7 = 1 is control byte C. From it, bit 6 drives cp_hi_o, bit 5 drives test_mode_o, bit 4 drives cp_off_o and bit 0 drives drv_off_o. The next byte D sets port_en_o = {D[7], D[6], D[3], D[2], D[1], D[0]}, and a 1 turns a port on.
- R6: Any number of byte pairs of either kind are taken in one transfer without a new address byte.
- R7: A data byte cut short by a stop leaves the register it targeted unchanged.
- R8: In a read transfer, each byte sent is {POR, lock_i, port_lvl_i[2:0], adc_code_i[2:0]}, MSB first. A master acknowledge after a byte causes another byte to be sent, sampled afresh.
- R9: A master not-acknowledge ends the read. SDA is released and stays released until the next start.
- R10: POR reads 1 from reset. It clears only when a read transfer is ended by a stop, and write transfers leave it set.
- R11: Out of reset div_ratio_o = 0, port_en_o = 0, all control outputs are 0 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset (power-up) |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| addr_sel_i | input | 2 | Variable address bits |
| lock_i | input | 1 | PLL lock indication |
| port_lvl_i | input | 3 | Sensed port levels, reported as status bits 5..3 |
| adc_code_i | input | 3 | ADC code, reported as status bits 2..0 |
| div_ratio_o | output | 15 | Divider ratio |
| cp_hi_o | output | 1 | Charge-pump high-current select |
| test_mode_o | output | 1 | Phase-comparator test routing |
| cp_off_o | output | 1 | Charge-pump disable |
| drv_off_o | output | 1 | Varactor drive output disable |
| port_en_o | output | 6 | Output-port enables {P7,P6,P3,P2,P1,P0} |

## Verification
The assertions assume that SCL stays high or low for several system clocks, so that every edge passes the synchroniser and is seen as one rise or fall. They also assume that the master changes SDA only while SCL is low, except to make a start or a stop. The bench drives the master with SCL phases twenty clocks long and moves SDA only in the low phase. It releases SDA in every acknowledge slot that the slave owns, so the bus line is always the AND of the master's drive and the inverse of sda_pull_o.

// File: rtl/synth_ctl_pkg.sv
package synth_ctl_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK
  } bus_state_e;
endpackage

// File: rtl/synth_bus_sync.sv
module synth_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic              scl_d, sda_d;
  logic              scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_s      = scl_q[STAGES-1];
  assign sda_o      = sda_q[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  // bus conditions: SDA moves while SCL held high
  assign start_o    = scl_s & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/synth_i2c_engine.sv
module synth_i2c_engine
  import synth_ctl_pkg::*;
#(
  parameter logic [4:0] ADDR_FIXED = 5'b11000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [1:0]        addr_sel_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic              sda_pull_o,
  output logic              byte_stb_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              rd_stop_o
);
  bus_state_e        state_q;
  logic [3:0]        cnt_q;
  logic [BYTE_W-1:0] sh_q, tx_q;
  logic              rw_q, rd_xfer_q, mack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      sh_q       <= '0;
      tx_q       <= '0;
      rw_q       <= 1'b0;
      rd_xfer_q  <= 1'b0;
      mack_q     <= 1'b0;
      byte_stb_o <= 1'b0;
      rd_stop_o  <= 1'b0;
    end else begin
      byte_stb_o <= 1'b0;
      rd_stop_o  <= 1'b0;
      if (start_i) begin
        state_q   <= ST_ADDR;
        cnt_q     <= '0;
        rd_xfer_q <= 1'b0;
      end else if (stop_i) begin
        state_q   <= ST_IDLE;
        rd_stop_o <= rd_xfer_q;
        rd_xfer_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_WR_BYTE: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall_i && cnt_q == 4'd8) begin
              if (state_q == ST_WR_BYTE) begin
                state_q <= ST_WR_ACK;
              end else if (sh_q[7:1] == {ADDR_FIXED, addr_sel_i}) begin
                state_q <= ST_ADDR_ACK;
                rw_q    <= sh_q[0];
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall_i) begin
            cnt_q <= '0;
            if (rw_q) begin
              state_q   <= ST_RD_BYTE;
              tx_q      <= status_i;
              rd_xfer_q <= 1'b1;
            end else begin
              state_q <= ST_WR_BYTE;
            end
          end
          ST_WR_ACK: if (scl_fall_i) begin
            byte_stb_o <= 1'b1;  // byte counts only once its ack slot completes
            state_q    <= ST_WR_BYTE;
            cnt_q      <= '0;
          end
          ST_RD_BYTE: if (scl_fall_i) begin
            if (cnt_q == 4'd7) begin
              state_q <= ST_RD_ACK;
            end else begin
              tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
              cnt_q <= cnt_q + 4'd1;
            end
          end
          ST_RD_ACK: begin
            if (scl_rise_i) begin
              mack_q <= ~sda_i;
            end else if (scl_fall_i) begin
              if (mack_q) begin
                state_q <= ST_RD_BYTE;
                tx_q    <= status_i;
                cnt_q   <= '0;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign byte_o     = sh_q;
  assign sda_pull_o = (state_q == ST_ADDR_ACK) || (state_q == ST_WR_ACK) ||
                      (state_q == ST_RD_BYTE && !tx_q[BYTE_W-1]);

  // R2: a byte strobe is a single-cycle pulse
  a_r2_stb_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_stb_o |=> !byte_stb_o);
  // R9: after a stop the line is released
  a_r9_release_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_pull_o);
  // R9: master nack returns to idle with SDA released
  a_r9_nack_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD_ACK && scl_fall_i && !mack_q && !start_i && !stop_i)
      |=> (state_q == ST_IDLE && !sda_pull_o));
  // R1: no acknowledge drive while waiting for a start
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !start_i) |=> !sda_pull_o);
endmodule

// File: rtl/synth_tune_regs.sv
module synth_tune_regs
  import synth_ctl_pkg::*;
#(
  parameter int DIV_W  = 15,
  parameter int PORT_N = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              byte_stb_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              rd_stop_i,
  output logic [DIV_W-1:0]  div_ratio_o,
  output logic              cp_hi_o,
  output logic              test_mode_o,
  output logic              cp_off_o,
  output logic              drv_off_o,
  output logic [PORT_N-1:0] port_en_o,
  output logic              por_o
);
  localparam int HI_W  = DIV_W - BYTE_W;
  localparam int LO_PN = PORT_N - 2;

  logic            second_q, kind_ctl_q;
  logic [HI_W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      second_q    <= 1'b0;
      kind_ctl_q  <= 1'b0;
      stage_q     <= '0;
      div_ratio_o <= '0;
      cp_hi_o     <= 1'b0;
      test_mode_o <= 1'b0;
      cp_off_o    <= 1'b0;
      drv_off_o   <= 1'b0;
      port_en_o   <= '0;
      por_o       <= 1'b1;
    end else begin
      if (rd_stop_i) por_o <= 1'b0;
      if (start_i) begin
        second_q <= 1'b0;
      end else if (byte_stb_i) begin
        if (!second_q) begin
          second_q   <= 1'b1;
          kind_ctl_q <= byte_i[BYTE_W-1];
          if (byte_i[BYTE_W-1]) begin
            cp_hi_o     <= byte_i[6];
            test_mode_o <= byte_i[5];
            cp_off_o    <= byte_i[4];
            drv_off_o   <= byte_i[0];
          end else begin
            stage_q <= byte_i[HI_W-1:0];
          end
        end else begin
          second_q <= 1'b0;
          if (kind_ctl_q) port_en_o   <= {byte_i[7:6], byte_i[LO_PN-1:0]};
          else            div_ratio_o <= {stage_q, byte_i};
        end
      end
    end
  end

  // R4: divider only moves on a byte strobe
  a_r4_div_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_stb_i |=> $stable(div_ratio_o));
  // R5: port enables only move on a byte strobe
  a_r5_port_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_stb_i |=> $stable(port_en_o));
  // R10: the power-on flag never sets again once cleared
  a_r10_por_sticky_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !por_o |=> !por_o);
endmodule

// File: rtl/synth_ctl_i2c.sv
module synth_ctl_i2c
  import synth_ctl_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         DIV_W       = 15,
  parameter int         PORT_N      = 6,
  parameter logic [4:0] ADDR_FIXED  = 5'b11000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic [1:0]        addr_sel_i,
  input  logic              lock_i,
  input  logic [2:0]        port_lvl_i,
  input  logic [2:0]        adc_code_i,
  output logic [DIV_W-1:0]  div_ratio_o,
  output logic              cp_hi_o,
  output logic              test_mode_o,
  output logic              cp_off_o,
  output logic              drv_off_o,
  output logic [PORT_N-1:0] port_en_o
);
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              byte_stb, rd_stop, por;
  logic [BYTE_W-1:0] byte_data, status;

  assign status = {por, lock_i, port_lvl_i, adc_code_i};

  synth_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  synth_i2c_engine #(.ADDR_FIXED(ADDR_FIXED)) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .addr_sel_i (addr_sel_i),
    .status_i   (status),
    .sda_pull_o (sda_pull_o),
    .byte_stb_o (byte_stb),
    .byte_o     (byte_data),
    .rd_stop_o  (rd_stop)
  );

  synth_tune_regs #(.DIV_W(DIV_W), .PORT_N(PORT_N)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_det),
    .byte_stb_i  (byte_stb),
    .byte_i      (byte_data),
    .rd_stop_i   (rd_stop),
    .div_ratio_o (div_ratio_o),
    .cp_hi_o     (cp_hi_o),
    .test_mode_o (test_mode_o),
    .cp_off_o    (cp_off_o),
    .drv_off_o   (drv_off_o),
    .port_en_o   (port_en_o),
    .por_o       (por)
  );
endmodule

// File: tb/tb_synth_ctl_i2c.sv
module tb_synth_ctl_i2c;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1, sda_m = 1'b1;
  logic        sda_pull;
  logic [1:0]  addr_sel = 2'b10;
  logic        lock = 1'b0;
  logic [2:0]  port_lvl = 3'b000, adc = 3'b000;
  logic [14:0] div_ratio;
  logic        cp_hi, test_mode, cp_off, drv_off;
  logic [5:0]  port_en;
  wire         sda_bus = sda_m & ~sda_pull;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_ctl_i2c dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .addr_sel_i(addr_sel), .lock_i(lock),
    .port_lvl_i(port_lvl), .adc_code_i(adc), .div_ratio_o(div_ratio),
    .cp_hi_o(cp_hi), .test_mode_o(test_mode), .cp_off_o(cp_off),
    .drv_off_o(drv_off), .port_en_o(port_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hp();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp();
    sda_m = 1'b0; hp(); scl_m = 1'b0; hp();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hp(); scl_m = 1'b1; hp(); sda_m = 1'b1; hp();
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      sda_m = v[7-i]; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0; hp();
    end
  endtask

  task automatic write_byte(input logic [7:0] v, output logic ack_n);
    send_bits(v, 8);
    sda_m = 1'b1; hp(); scl_m = 1'b1;
    repeat (HALF/2) @(negedge clk);
    ack_n = sda_bus;
    repeat (HALF/2) @(negedge clk);
    scl_m = 1'b0; hp();
  endtask

  task automatic read_byte(input bit mack, output logic [7:0] v);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      hp(); scl_m = 1'b1;
      repeat (HALF/2) @(negedge clk);
      v[7-i] = sda_bus;
      repeat (HALF/2) @(negedge clk);
      scl_m = 1'b0;
    end
    hp(); sda_m = mack ? 1'b0 : 1'b1;
    hp(); scl_m = 1'b1; hp(); scl_m = 1'b0; hp();
    sda_m = 1'b1;
  endtask

  task automatic t_reset();
    check("R11 div", div_ratio, 0);
    check("R11 ports", port_en, 0);
    check("R11 ctrl", {cp_hi, test_mode, cp_off, drv_off}, 0);
    check("R11 sda", sda_pull, 0);
  endtask

  task automatic t_bad_addr();
    logic a;
    bus_start(); write_byte(8'hC0, a); bus_stop();
    check("R1 mismatch no ack", a, 1);
    check("R1 mismatch div", div_ratio, 0);
  endtask

  task automatic t_div_write();
    logic a;
    bus_start();
    write_byte(8'hC4, a); check("R1 match ack", a, 0);
    write_byte(8'h12, a); check("R2 ack A", a, 0);
    check("R4 no half update", div_ratio, 0);
    write_byte(8'h34, a); check("R2 ack B", a, 0);
    bus_stop();
    check("R3 ratio", div_ratio, 15'h1234);
  endtask

  task automatic t_half_pair();
    logic a;
    bus_start(); write_byte(8'hC4, a); write_byte(8'h05, a); bus_stop();
    check("R4 lone A dropped", div_ratio, 15'h1234);
    bus_start(); write_byte(8'hC4, a); write_byte(8'h34, a); write_byte(8'h56, a); bus_stop();
    check("R4 pairing restarts", div_ratio, 15'h3456);
  endtask

  task automatic t_ctrl();
    logic a;
    bus_start(); write_byte(8'hC4, a); write_byte(8'hDF, a); write_byte(8'hC5, a); bus_stop();
    check("R5 ctrl DF", {cp_hi, test_mode, cp_off, drv_off}, 4'b1011);
    check("R5 ports C5", port_en, 6'b110101);
    check("R5 div untouched", div_ratio, 15'h3456);
    bus_start(); write_byte(8'hC4, a); write_byte(8'hA0, a); write_byte(8'h00, a); bus_stop();
    check("R5 ctrl A0", {cp_hi, test_mode, cp_off, drv_off}, 4'b0100);
    check("R5 ports off", port_en, 6'b000000);
  endtask

  task automatic t_stream();
    logic a;
    bus_start(); write_byte(8'hC4, a);
    write_byte(8'h01, a); write_byte(8'h02, a);
    check("R6 first pair", div_ratio, 15'h0102);
    write_byte(8'hC0, a); write_byte(8'h0F, a);
    write_byte(8'h7F, a); write_byte(8'hFF, a);
    check("R6 last ack", a, 0);
    bus_stop();
    check("R6 div", div_ratio, 15'h7FFF);
    check("R6 ctrl", {cp_hi, test_mode, cp_off, drv_off}, 4'b1000);
    check("R6 ports", port_en, 6'b001111);
  endtask

  task automatic t_trunc();
    logic a;
    bus_start(); write_byte(8'hC4, a); write_byte(8'h11, a); send_bits(8'hAA, 3); bus_stop();
    check("R7 cut B", div_ratio, 15'h7FFF);
    bus_start(); write_byte(8'hC4, a); send_bits(8'hFF, 5); bus_stop();
    check("R7 cut C", {cp_hi, test_mode, cp_off, drv_off}, 4'b1000);
    check("R7 cut C ports", port_en, 6'b001111);
  endtask

  task automatic t_read();
    logic a;
    logic [7:0] v;
    lock = 1'b1; port_lvl = 3'b101; adc = 3'b011;
    bus_start(); write_byte(8'hC5, a);
    check("R1 read ack", a, 0);
    adc = 3'b110;
    read_byte(1'b1, v); check("R8 R10 status POR set", v, 8'hEB);
    read_byte(1'b0, v); check("R8 repeat fresh", v, 8'hEE);
    check("R9 released", sda_pull, 0);
    hp(); scl_m = 1'b1;
    repeat (HALF/2) @(negedge clk);
    check("R9 slot stays high", sda_bus, 1);
    repeat (HALF/2) @(negedge clk);
    scl_m = 1'b0; hp();
    bus_stop();
    bus_start(); write_byte(8'hC5, a);
    read_byte(1'b0, v); check("R10 POR cleared", v, 8'h6E);
    bus_stop();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_bad_addr();
    t_div_write();
    t_half_pair();
    t_ctrl();
    t_stream();
    t_trunc();
    t_read();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule